// File: doc/BRIEF.md
# Decimal and Unpacked-Digit Adjust Unit

This block corrects an 8-bit accumulator pair (a high byte and a low byte) after an ordinary binary add, subtract or multiply, or before a binary divide. The result can then be read as packed BCD (two decimal digits per byte) or as unpacked digits (one decimal digit per byte). The block is purely combinational. The caller presents both bytes, the incoming auxiliary carry and carry flags, and an operation code. In the same cycle it returns the corrected bytes, new auxiliary carry and carry, and the sign, zero and parity of the corrected low byte. It also returns a mask that marks which of those flags are meaningful for the selected operation.

Six operations are supported:

- Unpacked-digit correction after an add, and after a subtract.
- Packed-BCD correction after an add, and after a subtract.
- Splitting a binary byte into two decimal digits (after a multiply).
- Merging two decimal digits into a binary byte (before a divide).

Register storage, instruction decode and the binary arithmetic that comes before the correction stay with the caller.

Top module: `bcd_adjust_unit`

## Requirements
- R1: `op_sel` encodings: 0 is unpacked add-correct, 1 is unpacked subtract-correct, 2 is packed add-correct, 3 is packed subtract-correct, 4 is split, 5 is merge. For code 0, the condition is "low nibble of `al_in` greater than 9, or `af_in` is 1". When it holds, `al_out` = (`al_in`+6) & 0x0F, `ah_out` = `ah_in`+1 mod 256, and `af_out` = `cf_out` = 1.
- R2: For codes 0 and 1 with the condition false, `al_out` = `al_in` & 0x0F, `ah_out` = `ah_in`, and `af_out` = `cf_out` = 0. For codes 0 and 1, the upper nibble of `al_out` is always zero and `af_out` equals `cf_out`.
- R3: For code 1 with the condition true, `al_out` = (`al_in`-6 mod 256) & 0x0F, `ah_out` = `ah_in`-1 mod 256, and `af_out` = `cf_out` = 1.
- R4: For code 2, the low step applies when the low nibble of `al_in` is above 9 or `af_in` is 1. The high step applies when the original `al_in` is above 0x99 or `cf_in` is 1. The result is `al_out` = `al_in` + (low step ? 0x06 : 0) + (high step ? 0x60 : 0) mod 256. `af_out` reports the low step, `cf_out` reports the high step, and `ah_out` = `ah_in`.
- R5: Code 3 uses the same two conditions as R4, but subtracts 0x06 and 0x60 instead of adding them. Its flags and `ah_out` behave as in R4.
- R6: For code 4, `ah_out` = `al_in` / 10 and `al_out` = `al_in` mod 10. `af_out` and `cf_out` are 0.
- R7: For code 5, `al_out` = (`ah_in`*10 + `al_in`) mod 256 and `ah_out` = 0. `af_out` and `cf_out` are 0.
- R8: For every code, the three result flags are computed from `al_out`:
  - `sf_out` is bit 7 of `al_out`.
  - `zf_out` is 1 when `al_out` is zero.
  - `pf_out` is 1 when `al_out` has an even number of set bits.
- R9: `flag_valid` bit positions are [0] carry, [1] parity, [2] auxiliary, [3] zero, [4] sign. The mask is 5'b00101 for codes 0 and 1, 5'b11111 for codes 2 and 3, and 5'b11010 for codes 4 and 5.
- R10: Codes 6 and 7 pass both bytes through unchanged. For these codes `af_out` = `cf_out` = 0 and `flag_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code |
| al_in | input | 8 | Low accumulator byte before correction |
| ah_in | input | 8 | High accumulator byte before correction |
| af_in | input | 1 | Incoming auxiliary (nibble) carry |
| cf_in | input | 1 | Incoming carry |
| al_out | output | 8 | Corrected low byte |
| ah_out | output | 8 | Corrected high byte |
| af_out | output | 1 | New auxiliary carry |
| cf_out | output | 1 | New carry |
| sf_out | output | 1 | Sign of corrected low byte |
| zf_out | output | 1 | Corrected low byte is zero |
| pf_out | output | 1 | Even parity of corrected low byte |
| flag_valid | output | 5 | Which flags are meaningful for this code |

## Verification
The embedded assertions watch structural invariants that must hold whatever the operand:

- The unpacked results keep a clear upper nibble, and their auxiliary carry and carry are equal.
- An incoming carry forces a packed high step.
- The split digits recombine to the original byte, and the merge clears the high byte.
- The flag-valid mask matches the operation class.

The exact corrected values are shown only by the bench scenarios, which compare every output against an independent model. These include the boundary cases: a low nibble of exactly 9 or 10, an original byte of 0x99 against 0x9A, and wrap-around of the high byte and of the merged product.

// File: rtl/bcdadj_pkg.sv
package bcdadj_pkg;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;
  localparam int FLAG_N  = 5;

  typedef enum logic [2:0] {
    OP_UNP_ADD = 3'd0,
    OP_UNP_SUB = 3'd1,
    OP_PCK_ADD = 3'd2,
    OP_PCK_SUB = 3'd3,
    OP_SPLIT   = 3'd4,
    OP_MERGE   = 3'd5
  } adj_op_e;

  localparam int VB_CARRY = 0;
  localparam int VB_PAR   = 1;
  localparam int VB_AUX   = 2;
  localparam int VB_ZERO  = 3;
  localparam int VB_SIGN  = 4;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic              aux;
    logic              carry;
  } adj_res_t;
endpackage

// File: rtl/unpacked_adj.sv
module unpacked_adj
  import bcdadj_pkg::*;
#(
  parameter int DIGIT_MAX = 9
) (
  input  logic              sub_mode,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic [BYTE_W-1:0] hi_in,
  input  logic              aux_in,
  output adj_res_t          res
);
  localparam logic [BYTE_W-1:0] STEP    = BYTE_W'(DIGIT_MAX - 3);
  localparam logic [BYTE_W-1:0] LO_MASK = BYTE_W'((1 << NIB_W) - 1);

  logic              fix;
  logic [BYTE_W-1:0] lo_corr;

  always_comb begin
    fix     = (32'(lo_in[NIB_W-1:0]) > DIGIT_MAX) || aux_in;
    lo_corr = lo_in;
    res.hi  = hi_in;
    if (fix) begin
      lo_corr = sub_mode ? (lo_in - STEP) : (lo_in + STEP);
      res.hi  = sub_mode ? (hi_in - 1'b1) : (hi_in + 1'b1);
    end
    res.lo    = lo_corr & LO_MASK;
    res.aux   = fix;
    res.carry = fix;
  end

  always_comb begin
    a_r2_upper_clear: assert (res.lo[BYTE_W-1:NIB_W] == '0)
      else $error("unpacked result has upper nibble set");
    a_r2_flags_equal: assert (res.aux == res.carry)
      else $error("unpacked aux and carry differ");
  end
endmodule

// File: rtl/packed_adj.sv
module packed_adj
  import bcdadj_pkg::*;
#(
  parameter int DIGIT_MAX = 9
) (
  input  logic              sub_mode,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic [BYTE_W-1:0] hi_in,
  input  logic              aux_in,
  input  logic              carry_in,
  output adj_res_t          res
);
  localparam logic [BYTE_W-1:0] LO_STEP = BYTE_W'(DIGIT_MAX - 3);
  localparam logic [BYTE_W-1:0] HI_STEP = LO_STEP << NIB_W;
  localparam logic [BYTE_W-1:0] UPPER   = BYTE_W'((DIGIT_MAX << NIB_W) | DIGIT_MAX);

  logic              lo_fix, hi_fix;
  logic [BYTE_W-1:0] delta;

  always_comb begin
    lo_fix    = (32'(lo_in[NIB_W-1:0]) > DIGIT_MAX) || aux_in;
    hi_fix    = (lo_in > UPPER) || carry_in;
    delta     = (lo_fix ? LO_STEP : '0) | (hi_fix ? HI_STEP : '0);
    res.lo    = sub_mode ? (lo_in - delta) : (lo_in + delta);
    res.hi    = hi_in;
    res.aux   = lo_fix;
    res.carry = hi_fix;
  end

  always_comb begin
    a_r4_carry_forces_high: assert (!carry_in || res.carry)
      else $error("incoming carry did not force high step");
    a_r4_aux_forces_low: assert (!aux_in || res.aux)
      else $error("incoming aux did not force low step");
  end
endmodule

// File: rtl/radix_adj.sv
module radix_adj
  import bcdadj_pkg::*;
#(
  parameter int RADIX = 10
) (
  input  logic              merge_mode,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic [BYTE_W-1:0] hi_in,
  output adj_res_t          res
);
  localparam int PROD_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] RDX = BYTE_W'(RADIX);

  logic [PROD_W-1:0] prod;
  logic [BYTE_W-1:0] quot, rem;

  always_comb begin
    quot = lo_in / RDX;
    rem  = lo_in % RDX;
    prod = PROD_W'(hi_in) * PROD_W'(RDX) + PROD_W'(lo_in);
    if (merge_mode) begin
      res.lo = prod[BYTE_W-1:0];
      res.hi = '0;
    end else begin
      res.lo = rem;
      res.hi = quot;
    end
    res.aux   = 1'b0;
    res.carry = 1'b0;
  end

  always_comb begin
    if (!merge_mode) begin
      a_r6_split_rebuilds: assert (PROD_W'(res.hi) * PROD_W'(RDX) + PROD_W'(res.lo) == PROD_W'(lo_in)
                                   && res.lo < RDX)
        else $error("split digits do not rebuild the input");
    end else begin
      a_r7_merge_hi_zero: assert (res.hi == '0)
        else $error("merge left high byte nonzero");
    end
  end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcdadj_pkg::*;
#(
  parameter int RADIX = 10
) (
  input  logic [2:0]        op_sel,
  input  logic [BYTE_W-1:0] al_in,
  input  logic [BYTE_W-1:0] ah_in,
  input  logic              af_in,
  input  logic              cf_in,
  output logic [BYTE_W-1:0] al_out,
  output logic [BYTE_W-1:0] ah_out,
  output logic              af_out,
  output logic              cf_out,
  output logic              sf_out,
  output logic              zf_out,
  output logic              pf_out,
  output logic [FLAG_N-1:0] flag_valid
);
  localparam int DIGIT_MAX = RADIX - 1;

  adj_res_t unp_r, pck_r, rdx_r, sel_r;

  unpacked_adj #(.DIGIT_MAX(DIGIT_MAX)) u_unp (
    .sub_mode (op_sel == OP_UNP_SUB),
    .lo_in    (al_in),
    .hi_in    (ah_in),
    .aux_in   (af_in),
    .res      (unp_r)
  );

  packed_adj #(.DIGIT_MAX(DIGIT_MAX)) u_pck (
    .sub_mode (op_sel == OP_PCK_SUB),
    .lo_in    (al_in),
    .hi_in    (ah_in),
    .aux_in   (af_in),
    .carry_in (cf_in),
    .res      (pck_r)
  );

  radix_adj #(.RADIX(RADIX)) u_rdx (
    .merge_mode (op_sel == OP_MERGE),
    .lo_in      (al_in),
    .hi_in      (ah_in),
    .res        (rdx_r)
  );

  always_comb begin
    flag_valid = '0;
    unique case (op_sel)
      OP_UNP_ADD, OP_UNP_SUB: begin
        sel_r = unp_r;
        flag_valid[VB_AUX]   = 1'b1;
        flag_valid[VB_CARRY] = 1'b1;
      end
      OP_PCK_ADD, OP_PCK_SUB: begin
        sel_r = pck_r;
        flag_valid = '1;
      end
      OP_SPLIT, OP_MERGE: begin
        sel_r = rdx_r;
        flag_valid[VB_SIGN] = 1'b1;
        flag_valid[VB_ZERO] = 1'b1;
        flag_valid[VB_PAR]  = 1'b1;
      end
      default: begin
        sel_r = '{lo: al_in, hi: ah_in, aux: 1'b0, carry: 1'b0};
      end
    endcase
  end

  always_comb begin
    al_out = sel_r.lo;
    ah_out = sel_r.hi;
    af_out = sel_r.aux;
    cf_out = sel_r.carry;
    sf_out = sel_r.lo[BYTE_W-1];
    zf_out = (sel_r.lo == '0);
    pf_out = ~^sel_r.lo;
  end

  always_comb begin
    a_r9_mask_class: assert ((op_sel > 3'd5) ? (flag_valid == '0)
                             : (flag_valid[VB_SIGN] == flag_valid[VB_ZERO]))
      else $error("flag mask inconsistent with op class");
    a_r10_reserved_pass: assert (op_sel <= 3'd5 || (al_out == al_in && ah_out == ah_in
                                 && !af_out && !cf_out))
      else $error("reserved code altered state");
  end
endmodule

// File: tb/bcd_adjust_unit_tb_top.sv
module bcd_adjust_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0] op_sel;
  logic [7:0] al_in, ah_in, al_out, ah_out;
  logic af_in, cf_in, af_out, cf_out, sf_out, zf_out, pf_out;
  logic [4:0] flag_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  bcd_adjust_unit dut_i (
    .op_sel(op_sel), .al_in(al_in), .ah_in(ah_in), .af_in(af_in), .cf_in(cf_in),
    .al_out(al_out), .ah_out(ah_out), .af_out(af_out), .cf_out(cf_out),
    .sf_out(sf_out), .zf_out(zf_out), .pf_out(pf_out), .flag_valid(flag_valid)
  );

  typedef struct packed {
    logic [7:0] al; logic [7:0] ah; logic af; logic cf;
    logic sf; logic zf; logic pf; logic [4:0] vm;
  } exp_t;

  function automatic exp_t model(input logic [2:0] op, input logic [7:0] al,
                                 input logic [7:0] ah, input logic af, input logic cf);
    exp_t e;
    int ones;
    bit c1, c2;
    e.al = al; e.ah = ah; e.af = 0; e.cf = 0; e.vm = 5'b00000;
    c1 = (al % 16 > 9) || af;
    c2 = (al > 8'h99) || cf;
    case (op)
      3'd0, 3'd1: begin
        e.vm = 5'b00101;
        if (c1) begin
          e.al = (op == 3'd0) ? 8'(al + 6) : 8'(al - 6);
          e.ah = (op == 3'd0) ? 8'(ah + 1) : 8'(ah - 1);
          e.af = 1; e.cf = 1;
        end
        e.al = e.al % 16;
      end
      3'd2, 3'd3: begin
        e.vm = 5'b11111;
        if (op == 3'd2) e.al = 8'(int'(al) + (c1 ? 6 : 0) + (c2 ? 96 : 0));
        else            e.al = 8'(int'(al) - (c1 ? 6 : 0) - (c2 ? 96 : 0));
        e.af = c1; e.cf = c2;
      end
      3'd4: begin e.vm = 5'b11010; e.ah = al / 10; e.al = al % 10; end
      3'd5: begin e.vm = 5'b11010; e.al = 8'(int'(ah) * 10 + int'(al)); e.ah = 0; end
      default: ;
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += e.al[i];
    e.sf = e.al[7];
    e.zf = (e.al == 0);
    e.pf = (ones % 2 == 0);
    return e;
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [7:0] al, input logic [7:0] ah,
                       input logic af, input logic cf, input string rq);
    exp_t e, a;
    @(posedge clk);
    op_sel = op; al_in = al; ah_in = ah; af_in = af; cf_in = cf;
    @(negedge clk);
    e = model(op, al, ah, af, cf);
    a = '{al_out, ah_out, af_out, cf_out, sf_out, zf_out, pf_out, flag_valid};
    n_chk++;
    if ({a.al, a.ah, a.af, a.cf} !== {e.al, e.ah, e.af, e.cf}) begin
      n_bad++;
      $display("FAIL %s op=%0d in=%h/%h af=%b cf=%b: got al=%h ah=%h af=%b cf=%b exp al=%h ah=%h af=%b cf=%b",
               rq, op, al, ah, af, cf, a.al, a.ah, a.af, a.cf, e.al, e.ah, e.af, e.cf);
    end
    n_chk++;
    if ({a.sf, a.zf, a.pf} !== {e.sf, e.zf, e.pf}) begin
      n_bad++;
      $display("FAIL R8 op=%0d: got s/z/p=%b%b%b exp %b%b%b", op, a.sf, a.zf, a.pf, e.sf, e.zf, e.pf);
    end
    n_chk++;
    if (a.vm !== e.vm) begin
      n_bad++;
      $display("FAIL R9 op=%0d: got mask=%b exp %b", op, a.vm, e.vm);
    end
  endtask

  initial begin
    op_sel = 3'd6; al_in = 0; ah_in = 0; af_in = 0; cf_in = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state with a reserved code: pass-through, mask zero (R10)
    apply(3'd6, 8'h00, 8'h00, 0, 0, "R10");
    apply(3'd7, 8'hA5, 8'h3C, 1, 1, "R10");
    // R1: nibble above 9, and aux-forced correction
    apply(3'd0, 8'h0A, 8'h00, 0, 0, "R1");
    apply(3'd0, 8'h05, 8'hFF, 1, 0, "R1");
    // R2: boundary nibble 9 with no aux, upper bits masked off
    apply(3'd0, 8'hE9, 8'h12, 0, 1, "R2");
    apply(3'd1, 8'h37, 8'h40, 0, 0, "R2");
    // R3: subtract with high byte wrap
    apply(3'd1, 8'h03, 8'h00, 1, 0, "R3");
    // R4: 0x9A takes both steps to zero; 0x99 takes none
    apply(3'd2, 8'h9A, 8'h11, 0, 0, "R4");
    apply(3'd2, 8'h99, 8'h11, 0, 0, "R4");
    apply(3'd2, 8'h12, 8'h00, 0, 1, "R4");
    // R5: carry-only subtract, and low-nibble subtract
    apply(3'd3, 8'h00, 8'h00, 0, 1, "R5");
    apply(3'd3, 8'h2F, 8'h00, 0, 0, "R5");
    // R6: largest byte and zero
    apply(3'd4, 8'hFF, 8'h77, 1, 1, "R6");
    apply(3'd4, 8'h00, 8'h77, 0, 0, "R6");
    // R7: merged value wraps past 255
    apply(3'd5, 8'h09, 8'h19, 0, 0, "R7");
    apply(3'd5, 8'h07, 8'h04, 1, 1, "R7");
    void'($urandom(32'd1234));
    for (int i = 0; i < 2400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      apply(op, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), tag(op));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule